// File: doc/BRIEF.md
# Management Register Access Engine

This block lets a host read or write a 16-bit register in an attached Ethernet PHY, or in a serial EEPROM, through a small byte-wide register window. The host first loads a packed target byte. Its top two bits name the PHY and its low bits name the register. The host then loads a 16-bit data pair and writes a control byte that selects the target and starts a read or a write. A busy flag in the control byte stays set while the operation runs. When a read finishes, the data pair holds the returned value.

On the PHY path the engine produces a clause-22 management frame on MDC/MDIO, with MDC divided down from the system clock by a parameter. The EEPROM path is a stub. It keeps the engine busy for a fixed number of cycles, and it returns all ones on a read.

Top module: `mgmt_access_engine`

## Requirements
- R1: After reset the control, target, data-low and data-high bytes read 0, busy is 0, MDC is 0, MDIO output enable is 0 and MDIO output is 1.
- R2: The host window decodes offset 0x0B as control (bit 3 selects PHY when 1 and EEPROM when 0, bit 2 starts a read, bit 1 starts a write, bit 0 is read-only busy), 0x0C as target byte (bits 7:6 PHY number, bits 5:0 register), 0x0D as data low byte and 0x0E as data high byte. Read data appears on the cycle after the read strobe, and any other offset reads 0.
- R3: A control write from idle with bit 1 or bit 2 set makes busy read 1 until the operation ends, and it then returns to 0 without host action. Busy never rises without such a write.
- R4: A PHY frame has 64 bits, sent MSB first on rising MDC edges: 32 ones, start 01, opcode 10 (read) or 01 (write), a 5-bit PHY address equal to the 2-bit PHY number zero-extended, the low 5 bits of the register field, a 2-bit turnaround, and 16 data bits.
- R5: In a PHY write, the engine drives all 64 bits with the output enable high, sends turnaround 10, and sends the data pair as {high, low}. The data pair is left unchanged.
- R6: In a PHY read, the output enable is low from bit 46 (turnaround) to the end. MDIO input is sampled on the 16 rising MDC edges of bits 48..63, MSB first, and the result goes to the data pair when the operation completes.
- R7: Each MDC half period lasts MDC_HALF system clocks. MDC is 0 and the output enable is 0 whenever the engine is not busy.
- R8: While busy, host writes to the control, target and data bytes have no effect, and no new operation starts.
- R9: An EEPROM operation produces no MDC activity and stays busy for EE_CYCLES cycles. A read sets the data pair to 0xFFFF, and a write leaves it unchanged.
- R10: If bits 1 and 2 are both set in the start write, the engine performs a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | 8 | Host register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The assertions check on every cycle that MDC and the output enable stay quiet while idle or while an EEPROM operation runs, that busy rises only after a start write, and that the control bits and data pair do not move under host writes while busy. Only the bench scenarios can show the bit order of a frame, the point in a read where the output enable is released, the assembly of the sampled read data, the MDC period, and the stub results of the EEPROM path.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam logic [7:0] OFS_CTL = 8'h0B;
  localparam logic [7:0] OFS_TGT = 8'h0C;
  localparam logic [7:0] OFS_DLO = 8'h0D;
  localparam logic [7:0] OFS_DHI = 8'h0E;

  localparam int CB_BUSY = 0;
  localparam int CB_WR   = 1;
  localparam int CB_RD   = 2;
  localparam int CB_PHY  = 3;

  localparam int FRAME_BITS = 64;
  localparam int DATA_BITS  = 16;

  // Management frame, MSB is sent first
  function automatic logic [63:0] build_frame(input logic rd, input logic [4:0] phy,
                                              input logic [4:0] regn, input logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, regn,
            (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : wd)};
  endfunction
endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = $clog2(HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = run && (cnt == LAST);
  assign rise_evt = wrap && !mdc;
  assign fall_evt = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mgmt_mdio_shifter.sv
module mgmt_mdio_shifter #(
  parameter int FRAME_BITS = 64,
  parameter int DATA_W     = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic                  is_read_in,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic                  rise_evt,
  input  logic                  fall_evt,
  input  logic                  mdio_i,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  done
);
  localparam int CW         = $clog2(FRAME_BITS + 1);
  localparam int TA_FIRST   = FRAME_BITS - DATA_W - 2;
  localparam int DATA_FIRST = FRAME_BITS - DATA_W;

  logic [FRAME_BITS-1:0] shreg;
  logic [CW-1:0]         bitcnt;
  logic                  rd_q;

  assign mdio_o = shreg[FRAME_BITS-1];
  assign done   = fall_evt && (bitcnt == CW'(FRAME_BITS));

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '1;
      bitcnt  <= '0;
      rd_q    <= 1'b0;
      mdio_oe <= 1'b0;
      rd_data <= '0;
    end else if (load) begin
      shreg   <= frame;
      bitcnt  <= '0;
      rd_q    <= is_read_in;
      mdio_oe <= 1'b1;
    end else begin
      if (rise_evt) begin
        bitcnt <= bitcnt + 1'b1;
        if (rd_q && bitcnt >= CW'(DATA_FIRST))
          rd_data <= {rd_data[DATA_W-2:0], mdio_i};
      end
      if (fall_evt) begin
        if (done) begin
          shreg   <= '1;
          mdio_oe <= 1'b0;
        end else begin
          shreg   <= {shreg[FRAME_BITS-2:0], 1'b1};
          mdio_oe <= !(rd_q && bitcnt >= CW'(TA_FIRST));
        end
      end
    end
  end
endmodule

// File: rtl/mgmt_eeprom_stub.sv
module mgmt_eeprom_stub #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          active;

  assign done = active && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (load) begin
      active <= 1'b1;
      cnt    <= CW'(CYCLES - 1);
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/mgmt_access_engine.sv
module mgmt_access_engine
  import mgmt_pkg::*;
#(
  parameter int MDC_HALF  = 2,
  parameter int EE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_we,
  input  logic       host_re,
  input  logic [7:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       mdc,
  output logic       mdio_o,
  output logic       mdio_oe,
  input  logic       mdio_i
);
  logic [3:1]  ctl_q;
  logic        busy_q;
  logic        op_rd_q;
  logic        op_phy_q;
  logic [7:0]  tgt_q;
  logic [7:0]  dlo_q;
  logic [7:0]  dhi_q;

  logic        open_wr;
  logic        start;
  logic        start_rd;
  logic        phy_load;
  logic        ee_load;
  logic [63:0] frame;
  logic        rise_evt;
  logic        fall_evt;
  logic        phy_done;
  logic        ee_done;
  logic        fin;
  logic [15:0] phy_rd;

  assign open_wr  = host_we && !busy_q;
  assign start    = open_wr && (host_addr == OFS_CTL) &&
                    (host_wdata[CB_RD] || host_wdata[CB_WR]);
  assign start_rd = host_wdata[CB_RD];
  assign phy_load = start && host_wdata[CB_PHY];
  assign ee_load  = start && !host_wdata[CB_PHY];
  assign frame    = build_frame(start_rd, {3'b000, tgt_q[7:6]}, tgt_q[4:0], {dhi_q, dlo_q});
  assign fin      = busy_q && (op_phy_q ? phy_done : ee_done);

  mgmt_mdc_gen #(.HALF(MDC_HALF)) u_mdc (
    .clk(clk), .rst(rst), .run(busy_q && op_phy_q),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mgmt_mdio_shifter #(.FRAME_BITS(FRAME_BITS), .DATA_W(DATA_BITS)) u_shift (
    .clk(clk), .rst(rst), .load(phy_load), .is_read_in(start_rd), .frame(frame),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(phy_rd), .done(phy_done)
  );

  mgmt_eeprom_stub #(.CYCLES(EE_CYCLES)) u_ee (
    .clk(clk), .rst(rst), .load(ee_load), .done(ee_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      busy_q   <= 1'b0;
      op_rd_q  <= 1'b0;
      op_phy_q <= 1'b0;
      tgt_q    <= '0;
      dlo_q    <= '0;
      dhi_q    <= '0;
    end else begin
      if (open_wr) begin
        unique case (host_addr)
          OFS_CTL: ctl_q <= host_wdata[3:1];
          OFS_TGT: tgt_q <= host_wdata;
          OFS_DLO: dlo_q <= host_wdata;
          OFS_DHI: dhi_q <= host_wdata;
          default: ;
        endcase
      end
      if (start) begin
        busy_q   <= 1'b1;
        op_rd_q  <= start_rd;
        op_phy_q <= host_wdata[CB_PHY];
      end else if (fin) begin
        busy_q <= 1'b0;
        if (op_rd_q) begin
          {dhi_q, dlo_q} <= op_phy_q ? phy_rd : 16'hFFFF;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_re) begin
      unique case (host_addr)
        OFS_CTL: host_rdata <= {4'b0000, ctl_q, busy_q};
        OFS_TGT: host_rdata <= tgt_q;
        OFS_DLO: host_rdata <= dlo_q;
        OFS_DHI: host_rdata <= dhi_q;
        default: host_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mgmt_access_checker.sv
module mgmt_access_checker
  import mgmt_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        host_we,
  input logic [7:0]  host_addr,
  input logic [2:1]  start_bits,
  input logic        busy,
  input logic        op_phy,
  input logic [3:1]  ctl_bits,
  input logic [15:0] data_pair,
  input logic        mdc,
  input logic        mdio_oe
);
  // R3: busy rises only after a start write to the control byte
  p_busy_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(host_we && host_addr == OFS_CTL && (start_bits != 2'b00)));

  // R7: MDC rests low while idle
  p_mdc_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  // R7: MDIO released while idle
  p_oe_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);

  // R8: control write while busy leaves stored bits unchanged
  p_ctl_locked_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && host_we && host_addr == OFS_CTL) |=> $stable(ctl_bits));

  // R8: data pair does not move during an operation
  p_data_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(data_pair));

  // R9: EEPROM operation leaves the management clock silent
  p_ee_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !op_phy) |-> (!mdc && !mdio_oe));
endmodule

bind mgmt_access_engine mgmt_access_checker u_chk (
  .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
  .start_bits(host_wdata[2:1]), .busy(busy_q), .op_phy(op_phy_q),
  .ctl_bits(ctl_q), .data_pair({dhi_q, dlo_q}), .mdc(mdc), .mdio_oe(mdio_oe)
);

// File: tb/test_mgmt_access_engine.sv
module test_mgmt_access_engine;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int EE   = 16;
  localparam logic [7:0] A_CTL = 8'h0B, A_TGT = 8'h0C, A_DLO = 8'h0D, A_DHI = 8'h0E;

  // {is_read, phy[1:0], reg[5:0], write data, phy response}
  localparam logic [40:0] VEC [4] = '{
    {1'b0, 2'd1, 6'h04, 16'hA5C3, 16'h0000},
    {1'b1, 2'd2, 6'h11, 16'h0000, 16'hBEEF},
    {1'b1, 2'd3, 6'h3F, 16'h0000, 16'h8001},
    {1'b0, 2'd0, 6'h00, 16'hFFFF, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_we = 1'b0, host_re = 1'b0;
  logic [7:0] host_addr = '0, host_wdata = '0;
  logic [7:0] host_rdata;
  logic mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;

  int checks = 0, errors = 0, cyc = 0, rcnt = 0;
  logic cap_o [64];
  logic cap_oe [64];
  int   rise_cyc [64];
  logic [15:0] rsp_cur = '0;

  mgmt_access_engine #(.MDC_HALF(HALF), .EE_CYCLES(EE)) i_mgmt_access_engine (
    .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  // PHY model: capture each rising MDC edge, answer read data after falling edges
  always @(posedge mdc) begin
    if (rcnt < 64) begin
      cap_o[rcnt]    = mdio_o;
      cap_oe[rcnt]   = mdio_oe;
      rise_cyc[rcnt] = cyc;
    end
    rcnt++;
  end
  always @(negedge mdc) mdio_i = (rcnt >= 48 && rcnt < 64) ? rsp_cur[63 - rcnt] : 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); host_re = 1'b1; host_addr = a;
    @(negedge clk); host_re = 1'b0; d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] c;
    for (int i = 0; i < 3000; i++) begin
      rd(A_CTL, c);
      if (!c[0]) return;
    end
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(A_DLO, lo); rd(A_DHI, hi); v = {hi, lo};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b, t;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(mdc == 1'b0 && mdio_oe == 1'b0 && mdio_o == 1'b1, "R1 pins", {mdc, mdio_oe, mdio_o}, 3'b001);
    rd(A_CTL, b); check(b == 8'h00, "R1 ctl", b, 0);
    rd(A_TGT, b); check(b == 8'h00, "R1 tgt", b, 0);
    rd16(v);      check(v == 16'h0, "R1 data", v, 0);

    // R2 register window
    wr(A_TGT, 8'h96); rd(A_TGT, b); check(b == 8'h96, "R2 tgt", b, 8'h96);
    wr(A_DLO, 8'h3C); wr(A_DHI, 8'hC3); rd16(v); check(v == 16'hC33C, "R2 data", v, 16'hC33C);
    rd(8'h20, b); check(b == 8'h00, "R2 unmapped", b, 0);

    // Table-driven PHY operations: R3 R4 R5 R6
    foreach (VEC[k]) begin
      logic isr;
      logic [1:0] ph;
      logic [5:0] rg;
      logic [15:0] wd;
      logic [63:0] ef;
      int fm, om, last;
      {isr, ph, rg, wd, rsp_cur} = VEC[k];
      ef = {32'hFFFF_FFFF, 2'b01, (isr ? 2'b10 : 2'b01), 3'b000, ph, rg[4:0], 2'b10, wd};
      wr(A_TGT, {ph, rg}); wr(A_DLO, wd[7:0]); wr(A_DHI, wd[15:8]);
      rcnt = 0;
      wr(A_CTL, {4'b0000, 1'b1, isr, !isr, 1'b0});
      rd(A_CTL, b); check(b[0] == 1'b1, "R3 busy set", b[0], 1);
      wait_idle();
      rd(A_CTL, b); check(b[0] == 1'b0, "R3 busy clear", b[0], 0);
      check(rcnt == 64, "R4 frame length", rcnt, 64);
      last = isr ? 45 : 63;
      fm = 0; om = 0;
      for (int i = 0; i < 64; i++) begin
        if (i <= last && cap_o[i] != ef[63 - i]) fm++;
        if (cap_oe[i] != !(isr && i >= 46)) om++;
      end
      check(fm == 0, "R4 frame bits", fm, 0);
      check(om == 0, isr ? "R6 oe release" : "R5 oe drive", om, 0);
      rd16(v);
      if (isr) check(v == rsp_cur, "R6 read data", v, rsp_cur);
      else     check(v == wd, "R5 data kept", v, wd);
      wr(A_CTL, 8'h00);
    end
    check(rise_cyc[1] - rise_cyc[0] == 2 * HALF, "R7 mdc period", rise_cyc[1] - rise_cyc[0], 2 * HALF);

    // R8 host writes ignored while busy
    wr(A_TGT, 8'h41); rsp_cur = 16'h1357; rcnt = 0;
    wr(A_CTL, 8'h0C);
    wr(A_CTL, 8'h00); wr(A_TGT, 8'h55); wr(A_DLO, 8'h99);
    rd(A_CTL, b); check(b == 8'h0D, "R8 ctl locked", b, 8'h0D);
    wait_idle();
    rd(A_TGT, t); check(t == 8'h41, "R8 tgt locked", t, 8'h41);
    rd16(v); check(v == 16'h1357, "R8 data result", v, 16'h1357);
    check(rcnt == 64, "R8 no extra frame", rcnt, 64);
    wr(A_CTL, 8'h00);

    // R10 both start bits give a read
    rsp_cur = 16'h0F0F; rcnt = 0;
    wr(A_CTL, 8'h0E); wait_idle();
    check(cap_o[34] == 1'b1 && cap_o[35] == 1'b0, "R10 read opcode", {cap_o[34], cap_o[35]}, 2'b10);
    rd16(v); check(v == 16'h0F0F, "R10 read data", v, 16'h0F0F);
    wr(A_CTL, 8'h00);

    // R9 EEPROM stub
    wr(A_DLO, 8'h34); wr(A_DHI, 8'h12); rcnt = 0;
    wr(A_CTL, 8'h04);
    rd(A_CTL, b); check(b[0] == 1'b1, "R9 ee busy", b[0], 1);
    wait_idle();
    rd16(v); check(v == 16'hFFFF, "R9 ee read", v, 16'hFFFF);
    check(rcnt == 0, "R9 no mdc", rcnt, 0);
    wr(A_CTL, 8'h00);
    wr(A_DLO, 8'h5A); wr(A_DHI, 8'h5A);
    wr(A_CTL, 8'h02); wait_idle();
    rd16(v); check(v == 16'h5A5A, "R9 ee write", v, 16'h5A5A);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule